// File: doc/BRIEF.md
# Slow Bus to Shared RAM Bridge

This block lets a slow 8-bit processor bus use one port of an on-chip dual-port RAM. A fast co-processor owns the other port. The bridge runs on the fast internal clock and brings the bus phase clock and read/write line into that clock domain through a synchronizer. It decodes a fixed shared address window, from 0x2000 to 0x5FFF. Each slow bus access becomes a single fast-clock RAM operation, so neither side ever waits.

On a read, the RAM is read as soon as the address has been captured. The byte is held in an output register, and the data bus is driven with it while the phase clock stays high. On a write, the address arrives first and the data arrives later. The RAM write is therefore held back until the phase clock falls, and it uses the last byte sampled while the phase was high. The slow side can use any byte in the window as a mailbox slot, for example for keyboard or joystick state that the fast side polls.

If both ports write the same RAM word in the same fast cycle, the fast port wins and the bridge write is dropped.

Top module: `bus_dpram_bridge`

## Requirements
- R1: Only bus addresses from 0x2000 to 0x5FFF inclusive reach the RAM, at word offset (address − 0x2000). An access outside that range causes no RAM operation, and it does not alias onto any word in the window.
- R2: A write that hits the window reaches the RAM only after the phase clock has fallen. It stores the byte that was present on bus_din during the final part of the high phase, even if bus_din held another value earlier in that phase.
- R3: A read that hits the window makes exactly one RAM read. Its byte appears on bus_dout and stays there until the next read that hits the window, including across reads that miss.
- R4: bus_doe is high only while a read that hits the window has its phase clock high. For writes, for misses and while the phase clock is low, bus_doe is low.
- R5: If the fast port writes the RAM word that a bridge write targets, in the same fast cycle, the bridge write is suppressed and the fast port's byte remains.
- R6: Each slow write cycle that hits the window produces exactly one single-cycle RAM write. A read cycle produces no RAM write.
- R7: While rst_n is low and after it is released, bus_doe, mem_en and mem_we are low until a slow bus cycle occurs.
- R8: Any byte in the window can be written and read back from the slow bus, including the first and last addresses. Bytes that the fast port writes can be read from the slow bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_phi2 | input | 1 | Slow bus phase clock, asynchronous to clk |
| bus_rnw | input | 1 | Slow bus direction: 1 = read, 0 = write |
| bus_addr | input | 16 | Slow bus address, stable while bus_phi2 is high |
| bus_din | input | 8 | Data from the slow bus |
| bus_dout | output | 8 | Held read byte for the slow bus |
| bus_doe | output | 1 | Output enable for bus_dout |
| mem_en | output | 1 | RAM port enable |
| mem_we | output | 1 | RAM port write strobe |
| mem_addr | output | 14 | RAM word offset |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one clock after a read enable |
| fp_we | input | 1 | Fast port write strobe, used for collision priority |
| fp_addr | input | 14 | Fast port word offset, used for collision priority |

## Verification
Suppose the latched cycle state is wrong, for example the window flag or the direction. The effect shows within one phase period, either as a missing or extra RAM strobe near the phase edges or as bus_doe asserting during a write or a miss. A data capture that is too early or too late leaves a stale byte in RAM. That error stays hidden until a later slow read of the same address returns the wrong value, so reads of every written word follow the writes. A wrong offset or an aliasing decode shows up as a corrupted neighbouring word, and window-edge reads detect it.

// File: rtl/bridge_pkg.sv
// Shared constants and types for the slow bus to shared RAM bridge.
// Assumes the shared window is a contiguous address range.
package bridge_pkg;
    localparam int BUS_AW = 16;
    localparam int DW     = 8;
    localparam logic [BUS_AW-1:0] WIN_BASE = 16'h2000;
    localparam logic [BUS_AW-1:0] WIN_LAST = 16'h5FFF;
    localparam int MEM_AW = $clog2(int'(WIN_LAST) - int'(WIN_BASE) + 1);

    // Flags latched when a slow cycle starts.
    typedef struct packed {
        logic hit;
        logic rnw;
    } cyc_t;
endpackage

// File: rtl/bridge_sync.sv
// Multi-stage flop synchronizer for W independent single-bit signals.
// Assumes STAGES >= 2 and that each bit may be sampled independently.
module bridge_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bridge_decode.sv
// Window decode: flags an address inside [BASE, LAST] and gives its
// word offset from BASE. Purely combinational.
module bridge_decode #(
    parameter int BUS_AW = 16,
    parameter int MEM_AW = 14,
    parameter logic [BUS_AW-1:0] BASE = '0,
    parameter logic [BUS_AW-1:0] LAST = '1
) (
    input  logic [BUS_AW-1:0] addr,
    output logic              hit,
    output logic [MEM_AW-1:0] offset
);
    logic [BUS_AW-1:0] diff;

    // Range compare and offset subtraction.
    always_comb begin
        hit    = (addr >= BASE) && (addr <= LAST);
        diff   = addr - BASE;
        offset = diff[MEM_AW-1:0];
    end
endmodule

// File: rtl/bridge_rdlatch.sv
// Read data holding register: captures RAM read data when cap is high
// and holds it indefinitely otherwise.
module bridge_rdlatch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    // Load on capture strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   dout <= '0;
        else if (cap) dout <= din;
    end
endmodule

// File: rtl/bus_dpram_bridge.sv
// Bridge from a slow phase-clocked 8-bit bus to one port of a dual-port
// RAM. It assumes the following:
// - bus_addr is stable from before the phase clock rises until after it falls.
// - bus_rnw is stable for the whole cycle.
// - The phase clock stays high and stays low for several clk periods.
// Reads are issued right after the address is captured. Writes commit
// once, on the detected phase fall, and a same-word fast port write
// suppresses them.
module bus_dpram_bridge #(
    parameter int BUS_AW = bridge_pkg::BUS_AW,
    parameter int DW     = bridge_pkg::DW,
    parameter logic [BUS_AW-1:0] WIN_BASE = bridge_pkg::WIN_BASE,
    parameter logic [BUS_AW-1:0] WIN_LAST = bridge_pkg::WIN_LAST,
    parameter int SYNC_STAGES = 2,
    localparam int MEM_AW = $clog2(int'(WIN_LAST) - int'(WIN_BASE) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_phi2,
    input  logic              bus_rnw,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_din,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_doe,
    output logic              mem_en,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              fp_we,
    input  logic [MEM_AW-1:0] fp_addr
);
    import bridge_pkg::*;

    logic [1:0]        sync_q;
    logic              phi2_s, rnw_s, phi2_d;
    logic              phase_rise, phase_fall;
    logic              dec_hit;
    logic [MEM_AW-1:0] dec_off;
    cyc_t              cyc;
    logic [MEM_AW-1:0] cyc_off;
    logic [DW-1:0]     din_q;
    logic              rd_req, rd_cap;
    logic              wr_go, clash;

    bridge_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({bus_phi2, bus_rnw}),
        .q    (sync_q)
    );
    assign phi2_s = sync_q[1];
    assign rnw_s  = sync_q[0];

    bridge_decode #(
        .BUS_AW(BUS_AW), .MEM_AW(MEM_AW), .BASE(WIN_BASE), .LAST(WIN_LAST)
    ) u_dec (
        .addr  (bus_addr),
        .hit   (dec_hit),
        .offset(dec_off)
    );

    // Delayed synchronized phase for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) phi2_d <= 1'b0;
        else        phi2_d <= phi2_s;
    end

    assign phase_rise = phi2_s & ~phi2_d;
    assign phase_fall = ~phi2_s & phi2_d;

    // Latch cycle flags and offset at phase start; drop the hit at phase end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc     <= '0;
            cyc_off <= '0;
        end else if (phase_rise) begin
            cyc.hit <= dec_hit;
            cyc.rnw <= rnw_s;
            cyc_off <= dec_off;
        end else if (phase_fall) begin
            cyc.hit <= 1'b0;
        end
    end

    // Keep sampling bus data while the phase is high; the last sample wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      din_q <= '0;
        else if (phi2_s) din_q <= bus_din;
    end

    // Read request one cycle after the start, capture one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req <= 1'b0;
            rd_cap <= 1'b0;
        end else begin
            rd_req <= phase_rise & rnw_s & dec_hit;
            rd_cap <= rd_req;
        end
    end

    bridge_rdlatch #(.DW(DW)) u_rd (
        .clk  (clk),
        .rst_n(rst_n),
        .cap  (rd_cap),
        .din  (mem_rdata),
        .dout (bus_dout)
    );

    // Deferred write commit and RAM port drive.
    always_comb begin
        wr_go     = phase_fall & cyc.hit & ~cyc.rnw;
        clash     = fp_we & (fp_addr == cyc_off);
        mem_we    = wr_go & ~clash;
        mem_en    = rd_req | mem_we;
        mem_addr  = cyc_off;
        mem_wdata = din_q;
        bus_doe   = phi2_s & cyc.hit & cyc.rnw;
    end
endmodule

// File: rtl/bridge_checker.sv
// Protocol checker for bus_dpram_bridge, attached by bind. It observes
// only the ports and relates them over time.
module bridge_checker (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_phi2,
    input logic                         bus_rnw,
    input logic [bridge_pkg::BUS_AW-1:0] bus_addr,
    input logic                         bus_doe,
    input logic                         mem_en,
    input logic                         mem_we,
    input logic [bridge_pkg::MEM_AW-1:0] mem_addr,
    input logic                         fp_we,
    input logic [bridge_pkg::MEM_AW-1:0] fp_addr
);
    import bridge_pkg::*;

    // Write strobe lasts one cycle per slow write.
    a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // Commit happens only after the phase clock is low.
    a_r2_write_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!$past(bus_phi2) && mem_en));

    // Output enable only for an in-window read.
    a_r4_doe_read_hit: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (bus_rnw && bus_addr >= WIN_BASE && bus_addr <= WIN_LAST));

    // Never drive the bus while committing a write.
    a_r4_doe_not_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> !mem_we);

    // Fast port wins a same-word write.
    a_r5_fast_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && fp_we) |-> (mem_addr != fp_addr));
endmodule

bind bus_dpram_bridge bridge_checker u_chk (.*);

// File: tb/sim_bus_dpram_bridge.sv
// Scoreboard bench: the driver queues expected read bytes, the monitor
// compares them when the output enable drops.
module sim_bus_dpram_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_phi2 = 1'b0, bus_rnw = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_din = 8'h00;
    logic [7:0]  bus_dout;
    logic        bus_doe, mem_en, mem_we;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        fp_we = 1'b0;
    logic [13:0] fp_addr = '0;
    logic [7:0]  fp_wdata = '0;

    int errors = 0, checks = 0;
    int wr_cnt = 0, rd_cnt = 0, doe_rises = 0;
    logic doe_prev = 1'b0;
    logic [7:0] ram_m [int];
    logic [7:0] shadow [int];
    logic [7:0] exp_q [$];

    always #10 clk = ~clk;

    bus_dpram_bridge u0 (.*);

    function automatic logic [7:0] peek(input logic [7:0] m [int], input int a);
        return m.exists(a) ? m[a] : 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // RAM model: bridge port then fast port; the fast write lands last.
    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= peek(ram_m, int'(mem_addr));
            if (mem_we) ram_m[int'(mem_addr)] = mem_wdata;
        end
        if (fp_we) ram_m[int'(fp_addr)] = fp_wdata;
    end

    // Monitor: strobe counters and scoreboard compare on the falling edge of bus_doe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) wr_cnt++;
            if (mem_en && !mem_we) rd_cnt++;
            if (bus_doe && !doe_prev) doe_rises++;
            if (doe_prev && !bus_doe) begin
                if (exp_q.size() == 0) chk("R4 unexpected drive", 32'd1, 32'd0);
                else chk("R3 read data", {24'd0, bus_dout}, {24'd0, exp_q.pop_front()});
            end
        end
        doe_prev = bus_doe;
    end

    task automatic fp_write(input logic [13:0] off, input logic [7:0] d);
        @(negedge clk); fp_we = 1'b1; fp_addr = off; fp_wdata = d;
        @(negedge clk); fp_we = 1'b0;
        shadow[int'(off)] = d;
    endtask

    // One slow bus cycle; data is valid only late in the phase.
    task automatic slow_cycle(input logic rnw, input logic [15:0] a,
                              input logic [7:0] d, input logic clash);
        bit hit = (a >= 16'h2000) && (a <= 16'h5FFF);
        int off = int'(a) - 16'h2000;
        int w0 = wr_cnt, r0 = rd_cnt, e0 = doe_rises;
        if (rnw && hit) exp_q.push_back(peek(shadow, off));
        @(negedge clk); bus_addr = a; bus_rnw = rnw; bus_din = 8'hA5;
        repeat (10) @(negedge clk);
        bus_phi2 = 1'b1;
        repeat (12) @(negedge clk);
        bus_din = d;
        repeat (10) @(negedge clk);
        bus_phi2 = 1'b0;
        if (clash) begin
            repeat (2) @(negedge clk);
            fp_we = 1'b1; fp_addr = off[13:0]; fp_wdata = ~d;
            @(negedge clk); fp_we = 1'b0;
        end
        repeat (8) @(negedge clk);
        if (!rnw && hit) shadow[off] = clash ? ~d : d;
        chk(rnw ? "R1 read strobes" : "R6 write strobes", 32'(wr_cnt - w0),
            32'((!rnw && hit && !clash) ? 1 : 0));
        chk("R1 read count", 32'(rd_cnt - r0), 32'((rnw && hit) ? 1 : 0));
        chk("R4 drive count", 32'(doe_rises - e0), 32'((rnw && hit) ? 1 : 0));
    endtask

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        chk("R7 doe in reset", {31'd0, bus_doe}, 32'd0);
        chk("R7 en in reset", {31'd0, mem_en}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 doe after reset", {31'd0, bus_doe}, 32'd0);
        chk("R7 we after reset", {31'd0, mem_we}, 32'd0);
        // Writes at both window edges, mid, and two misses (0x6000 would alias to 0).
        slow_cycle(1'b0, 16'h2000, 8'h11, 1'b0);
        slow_cycle(1'b0, 16'h5FFF, 8'h22, 1'b0);
        slow_cycle(1'b0, 16'h3456, 8'h33, 1'b0);
        slow_cycle(1'b0, 16'h1FFF, 8'h44, 1'b0);
        slow_cycle(1'b0, 16'h6000, 8'h55, 1'b0);
        // R8 and R2: read back, late data must be the stored value.
        slow_cycle(1'b1, 16'h2000, 8'h00, 1'b0);
        slow_cycle(1'b1, 16'h5FFF, 8'h00, 1'b0);
        slow_cycle(1'b1, 16'h3456, 8'h00, 1'b0);
        // R3: a miss read leaves the held byte.
        held = bus_dout;
        slow_cycle(1'b1, 16'h1FFF, 8'h00, 1'b0);
        chk("R3 held across miss", {24'd0, bus_dout}, {24'd0, held});
        // R8: fast port data visible to slow bus.
        fp_write(14'h0100, 8'h77);
        slow_cycle(1'b1, 16'h2100, 8'h00, 1'b0);
        // R5: same-word collision keeps fast data.
        slow_cycle(1'b0, 16'h2200, 8'h12, 1'b1);
        slow_cycle(1'b1, 16'h2200, 8'h00, 1'b0);
        // R2: overwrite with a new late byte and read it.
        slow_cycle(1'b0, 16'h3456, 8'h9C, 1'b0);
        slow_cycle(1'b1, 16'h3456, 8'h00, 1'b0);
        repeat (5) @(negedge clk);
        chk("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule